// File: doc/BRIEF.md
# Successive-Approximation Digitizer Controller

This block is the digital half of an 8-bit successive-approximation converter. It owns the approximation register and drives its value out as the code for an external DAC. An external comparator reports whether the DAC output lies above the held analog sample. That decision is re-timed through a synchronizing flip-flop before the register uses it. The block resolves one bit per trial, starting at the MSB and ending at the LSB.

A conversion begins when `start_i` is pulsed while the block is idle. When the LSB decision is resolved, the block presents the parallel result with a one-cycle valid strobe. In that same cycle it raises the sample-and-hold pulse, so the sample for the next conversion is taken right after the last approximation. It also raises one sample pulse right after reset, so the first conversion has a sample to work on. The sample-and-hold, the DAC and the comparator are all outside the block.

Top module: `sar_digitizer_ctrl`

## Requirements
- R1: While reset is asserted, `sample_o` and `busy_o` are 1, `result_valid_o` is 0, and both `dac_code_o` and `result_o` are 0.
- R2: When start is accepted in idle, `dac_code_o` becomes 0x80 (only the MSB set) on the next cycle. Bits are then tried one at a time from bit 7 down to bit 0.
- R3: Each bit trial lasts two clocks. In the first clock the code is presented and the comparator is captured in the synchronizer. In the second clock the bit is cleared if the captured decision is 1 (DAC above sample), and the next lower bit is set at the same edge.
- R4: The result is the largest code not above the held sample. `result_valid_o` is high for exactly one cycle. `result_o` changes only at that strobe and holds its value until the next one.
- R5: `sample_o` is high for exactly one cycle: the cycle right after the LSB decision, which coincides with `result_valid_o`. It is also high in the first cycle after reset.
- R6: A start pulse while `busy_o` is high, including during the sample cycle, is ignored. The running conversion keeps its timing and its result.
- R7: `busy_o` rises on the cycle after start is accepted. `result_valid_o` occurs on the 17th busy cycle, and `busy_o` falls one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin a conversion (accepted only when idle) |
| cmp_above_i | input | 1 | Raw comparator decision: 1 when DAC output is above the held sample |
| sample_o | output | 1 | Sample-and-hold pulse |
| dac_code_o | output | 8 | Current approximation register value, drives the DAC |
| result_o | output | 8 | Last completed conversion result |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | Conversion or sample cycle in progress |

## Verification
The hardest situation to reach is one where the synchronizer delay changes the outcome. Because of that delay, each bit decision must use the comparator value captured for the code presented one cycle earlier. The bench models the sample-and-hold and the comparator combinationally from `dac_code_o`, so a design that consumed the decision a cycle early or late would resolve bits against the wrong code. Input levels at all-zero, all-one, mid-scale neighbours and alternating patterns make that visible in the result. Stray start pulses are placed inside the trial sequence and exactly on the sample cycle to probe the ignore rule.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRESENT = 2'd1,
    ST_DECIDE  = 2'd2,
    ST_SAMPLE  = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 1,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output sar_state_e    state_o,
  output logic [IW-1:0] bit_o,
  output logic          load_o,
  output logic          decide_o,
  output logic          last_o
);
  localparam int WCW = (SYNC_STAGES > 1) ? $clog2(SYNC_STAGES) : 1;
  localparam logic [IW-1:0]  TOP_BIT  = IW'(WIDTH - 1);
  localparam logic [WCW-1:0] WAIT_END = WCW'(SYNC_STAGES - 1);

  sar_state_e     state_q, state_d;
  logic [IW-1:0]  bit_q, bit_d;
  logic [WCW-1:0] wait_q, wait_d;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    wait_d  = wait_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PRESENT;
          bit_d   = TOP_BIT;
          wait_d  = '0;
        end
      end
      ST_PRESENT: begin
        if (wait_q == WAIT_END) state_d = ST_DECIDE;
        else                    wait_d  = wait_q + 1'b1;
      end
      ST_DECIDE: begin
        wait_d = '0;
        if (bit_q == '0) begin
          state_d = ST_SAMPLE;
        end else begin
          state_d = ST_PRESENT;
          bit_d   = bit_q - 1'b1;
        end
      end
      ST_SAMPLE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SAMPLE;
      bit_q   <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      wait_q  <= wait_d;
    end
  end

  assign state_o  = state_q;
  assign bit_o    = bit_q;
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign decide_o = (state_q == ST_DECIDE);
  assign last_o   = (bit_q == '0);
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int WIDTH = 8,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             decide_i,
  input  logic             last_i,
  input  logic [IW-1:0]    bit_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             valid_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] MSB = ONE << (WIDTH - 1);

  logic [WIDTH-1:0] sar_q, sar_d, res_q, res_d;
  logic             valid_q, valid_d;
  logic [WIDTH-1:0] trial_mask, lower_mask, resolved;

  assign trial_mask = ONE << bit_i;
  assign lower_mask = trial_mask >> 1;
  assign resolved   = sar_q & ~(cmp_i ? trial_mask : '0);

  always_comb begin
    sar_d   = sar_q;
    res_d   = res_q;
    valid_d = 1'b0;
    if (load_i) begin
      sar_d = MSB;
    end else if (decide_i) begin
      sar_d = resolved | lower_mask;
      if (last_i) begin
        res_d   = resolved;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q   <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      sar_q   <= sar_d;
      res_q   <= res_d;
      valid_q <= valid_d;
    end
  end

  assign code_o   = sar_q;
  assign result_o = res_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/sar_digitizer_ctrl.sv
module sar_digitizer_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_above_i,
  output logic             sample_o,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             result_valid_o,
  output logic             busy_o
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  sar_state_e    state;
  logic [IW-1:0] bit_idx;
  logic          load, decide, last, cmp_sync;

  sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_above_i),
    .q_o    (cmp_sync)
  );

  sar_seq #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .state_o  (state),
    .bit_o    (bit_idx),
    .load_o   (load),
    .decide_o (decide),
    .last_o   (last)
  );

  sar_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .decide_i (decide),
    .last_i   (last),
    .bit_i    (bit_idx),
    .cmp_i    (cmp_sync),
    .code_o   (dac_code_o),
    .result_o (result_o),
    .valid_o  (result_valid_o)
  );

  assign sample_o = (state == ST_SAMPLE);
  assign busy_o   = (state != ST_IDLE);
endmodule

// File: rtl/sar_digitizer_ctrl_chk.sv
module sar_digitizer_ctrl_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             sample_o,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] result_o,
  input logic             result_valid_o,
  input logic             busy_o
);
  localparam int CONV = WIDTH * (SYNC_STAGES + 1);
  localparam logic [WIDTH-1:0] MSB = WIDTH'(1) << (WIDTH - 1);

  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   busy_cnt <= 0;
    else if (!busy_o && start_i)   busy_cnt <= 1;
    else if (busy_o && busy_cnt != 0) busy_cnt <= busy_cnt + 1;
  end

  a_r2_first_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && dac_code_o == MSB));

  a_r4_one_cycle_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  a_r4_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> $stable(result_o));

  a_r5_sample_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> sample_o);

  a_r7_valid_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (busy_cnt == CONV + 1));

  a_r6_sample_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !busy_o);
endmodule

bind sar_digitizer_ctrl sar_digitizer_ctrl_chk #(
  .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .sample_o       (sample_o),
  .dac_code_o     (dac_code_o),
  .result_o       (result_o),
  .result_valid_o (result_valid_o),
  .busy_o         (busy_o)
);

// File: tb/sar_digitizer_ctrl_bench.sv
`timescale 1ns/1ps
module sar_digitizer_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cmp_above;
  logic       sample;
  logic [7:0] dac_code, result;
  logic       valid, busy;

  int vin = 0;
  int held_an = 0;
  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sar_digitizer_ctrl u_sar_digitizer_ctrl (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .cmp_above_i    (cmp_above),
    .sample_o       (sample),
    .dac_code_o     (dac_code),
    .result_o       (result),
    .result_valid_o (valid),
    .busy_o         (busy)
  );

  // analog models: sample-and-hold and comparator
  always @(posedge clk) if (sample) held_an <= vin;
  assign cmp_above = (int'(dac_code) > held_an);

  // behavioural reference
  bit m_samp = 1;
  int m_cnt = 0;
  bit m_valid = 0;
  int m_dac = 0;
  int m_res = 0;
  int m_held = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_samp = 1; m_cnt = 0; m_valid = 0; m_dac = 0; m_res = 0;
    end else if (m_samp) begin
      m_held = vin; m_samp = 0; m_valid = 0;
    end else if (m_cnt == 0) begin
      if (start) begin m_cnt = 1; m_dac = 128; end
    end else if (m_cnt == 16) begin
      m_res = m_held; m_dac = m_held; m_valid = 1; m_samp = 1; m_cnt = 0;
    end else begin
      int k;
      m_cnt++;
      k = 7 - (m_cnt - 1) / 2;
      m_dac = (m_held & ~((1 << (k + 1)) - 1) & 255) | (1 << k);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    check("R1/R7", "busy", int'(busy), int'(m_samp || m_cnt != 0));
    check("R5", "sample", int'(sample), int'(m_samp));
    check("R4", "valid", int'(valid), int'(m_valid));
    check("R2/R3", "dac_code", int'(dac_code), m_dac);
    check("R4", "result", int'(result), m_res);
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // convert: returns busy cycles from accept until valid strobe
  task automatic convert(input int v, input int stray_at, output int lat);
    @(negedge clk);
    vin = v;
    while (busy) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!valid) begin
      if (lat == stray_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
  endtask

  initial begin
    int lat;
    int vals[12] = '{0, 255, 128, 127, 85, 170, 1, 254, 64, 63, 200, 17};
    #1;
    // R1: state during reset
    @(negedge clk);
    check("R1", "reset sample", int'(sample), 1);
    check("R1", "reset busy", int'(busy), 1);
    check("R1", "reset valid", int'(valid), 0);
    check("R1", "reset dac", int'(dac_code), 0);
    check("R1", "reset result", int'(result), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    foreach (vals[i]) begin
      convert(vals[i], 0, lat);
      check("R7", "latency", lat, 17);
    end
    // R6: stray starts during the trials
    convert(99, 5, lat);
    check("R6", "latency with stray start", lat, 17);
    convert(33, 16, lat);
    check("R6", "latency with late stray start", lat, 17);
    // R6: start exactly on the sample cycle (valid cycle) is ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6", "busy after start on sample cycle", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R6", "no conversion started", int'(busy), 0);
    // R4: final conversion of a known held value
    convert(5, 0, lat);
    convert(7, 0, lat);
    check("R4", "result of held 5", int'(result), 5);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule